// File: doc/BRIEF.md
# Command-Driven Random Word Generator with Counted Reseed

This block is a memory-mapped random-word source that software drives through a small register file. Software writes a command code to start work. Code 1 fills the result registers with fresh 32-bit words. Code 2 re-keys the internal generator. Code 0 and code 3 do nothing. A mode bit chooses whether four or eight result words are produced. When a job finishes, a status flag is raised. Each status flag is cleared by writing a 1 to it, and an enable register decides whether a flag drives the interrupt line. A constant identification word can be read back. The random source is a 32-bit xorshift register that stands in for a physical noise source. It gives repeatable sequences and makes no claim to strength.

A block counter tracks how many 16-byte blocks have been produced since the last re-key. Once it reaches a programmed limit, the next generate command first runs an automatic re-key. That re-key lengthens the job by a fixed number of cycles and leaves the seed-done flag untouched.

The sequencer has three states:
- SQ_IDLE accepts commands.
- SQ_MIX waits MIX_CYC cycles and applies the re-key on its last cycle.
- SQ_GEN writes one result word per cycle.

The transitions are:
- SQ_IDLE to SQ_GEN on a generate command with no re-key due.
- SQ_IDLE to SQ_MIX on a seed command, or on a generate command with a re-key due.
- SQ_MIX to SQ_GEN after an automatic re-key.
- SQ_MIX to SQ_IDLE after a commanded seed.
- SQ_GEN to SQ_IDLE after the last word.

Top module: `cmd_trng`

## Requirements
- R1: After reset, the status register reads 0x1, meaning the ready flag is already set. All result registers, the mode, enable and block-limit registers read 0, and irq_o is low.
- R2: Offset 0xF0 reads 0x000046BC. The command offset 0x00 and every unmapped offset (for example 0x04 and 0x70) read 0.
- R3: Writing 1 in bits [1:0] of offset 0x00 while idle starts a job. With mode bit 3 of offset 0x08 clear, the next four cycles write RAND0..RAND3 (offsets 0x20..0x2C) and RAND4..RAND7 keep their values. Status bit 0 (offset 0x14) becomes set at the fourth clock edge after the command edge.
- R4: With mode bit 3 set, all eight result registers (0x20..0x3C) are written and status bit 0 becomes set at the eighth edge. The mode is captured when the command is accepted.
- R5: Each written word is the next state of a 32-bit xorshift: x ^= x<<13; x ^= x>>17; x ^= x<<5. The state starts at 0x2545F491 after reset and carries over from one job to the next.
- R6: Command 2 takes MIX_CYC = 4 cycles. It then replaces the state with step(state ^ 0x9E3779B9), sets status bit 1 (seed done), resets the block count, and leaves the result registers unchanged.
- R7: Command writes that arrive while a job is running, and command values 0 and 3, have no effect.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it set.
- R9: irq_o = ien[31] & ((ien[0] & status[0]) | (ien[1] & status[1])), where ien is offset 0x10.
- R10: Offset 0x60 holds the limit N (16 bits). Every job adds 1 (four words) or 2 (eight words) to the block count. If N is non-zero and the count is at least N when a generate command is accepted, the 4-cycle re-key of R6 runs first, the count returns to 0, and status bit 0 is delayed by 4 cycles. This automatic re-key does not set status bit 1. N = 0 disables it.
- R11: Reading back returns only the implemented fields: mode bit 3, enable bits 31, 1 and 0, and limit bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe for this cycle |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the automatic re-key. It fires only after enough blocks have accumulated against the programmed limit, and only on the next generate command. Its only visible effect is a four-cycle shift in when the ready flag rises, together with a changed word stream. The stimulus reaches it in two ways. First it programs a limit of 2 and issues back-to-back four-word jobs. Then it programs a limit of 1 and issues eight-word jobs, so every job crosses the limit. The status register is polled every cycle against a behavioural queue-based model, so any lost or extra re-key cycle is caught. Commands issued in the middle of a job, including a seed, show that a running job cannot be interrupted.

// File: rtl/cmd_trng_pkg.sv
package cmd_trng_pkg;
    localparam int NUM_WORDS  = 8;
    localparam int HALF_WORDS = NUM_WORDS / 2;
    localparam int IDX_W      = $clog2(NUM_WORDS);

    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h08;
    localparam logic [7:0] OFS_IEN  = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h14;
    localparam logic [7:0] OFS_NBLK = 8'h60;
    localparam logic [7:0] OFS_VER  = 8'hF0;

    localparam logic [1:0] OP_GEN  = 2'd1;
    localparam logic [1:0] OP_SEED = 2'd2;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_MIX,
        SQ_GEN
    } seq_state_t;

    function automatic logic [31:0] xs_step(input logic [31:0] v);
        logic [31:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction
endpackage

// File: rtl/cmd_trng_src.sv
module cmd_trng_src
    import cmd_trng_pkg::*;
#(
    parameter logic [31:0] SEED_INIT = 32'h2545F491,
    parameter logic [31:0] MIX_KEY   = 32'h9E3779B9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    input  logic        mix,
    output logic [31:0] nxt_word
);
    logic [31:0] cur_q;

    assign nxt_word = xs_step(cur_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= SEED_INIT;
        else if (mix)
            cur_q <= xs_step(cur_q ^ MIX_KEY);
        else if (adv)
            cur_q <= nxt_word;
    end

    // R5
    state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q != 32'd0);
endmodule

// File: rtl/cmd_trng_fsm.sv
module cmd_trng_fsm
    import cmd_trng_pkg::*;
#(
    parameter int MIX_CYC = 4,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_gen,
    input  logic             start_seed,
    input  logic             wide_in,
    input  logic [CNT_W-1:0] nblk,
    output logic             idle,
    output logic             adv,
    output logic             mix,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             gen_done,
    output logic             seed_done
);
    localparam int CW = ($clog2(MIX_CYC) > IDX_W) ? $clog2(MIX_CYC) : IDX_W;
    localparam logic [CW-1:0]  MIX_LAST  = CW'(MIX_CYC - 1);
    localparam logic [CW-1:0]  WIDE_LAST = CW'(NUM_WORDS - 1);
    localparam logic [CW-1:0]  HALF_LAST = CW'(HALF_WORDS - 1);
    localparam logic [CNT_W:0] BLK_MAX   = '1;

    seq_state_t       state;
    logic [CW-1:0]    cnt;
    logic             wide_q;
    logic             then_gen;
    logic [CNT_W:0]   blk;
    logic [CNT_W+1:0] blk_sum;
    logic [CNT_W:0]   blk_nxt;
    logic             due;
    logic             last_word;

    assign due       = (nblk != '0) && (blk >= {1'b0, nblk});
    assign last_word = wide_q ? (cnt == WIDE_LAST) : (cnt == HALF_LAST);
    assign blk_sum   = {1'b0, blk} + {{CNT_W{1'b0}}, wide_q, ~wide_q};
    assign blk_nxt   = (blk_sum > {1'b0, BLK_MAX}) ? BLK_MAX : blk_sum[CNT_W:0];

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            wide_q   <= 1'b0;
            then_gen <= 1'b0;
            blk      <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    cnt <= '0;
                    if (start_gen) begin
                        wide_q <= wide_in;
                        if (due) begin
                            state    <= SQ_MIX;
                            then_gen <= 1'b1;
                            blk      <= '0;
                        end else begin
                            state <= SQ_GEN;
                        end
                    end else if (start_seed) begin
                        state    <= SQ_MIX;
                        then_gen <= 1'b0;
                        blk      <= '0;
                    end
                end
                SQ_MIX: begin
                    if (cnt == MIX_LAST) begin
                        cnt   <= '0;
                        state <= then_gen ? SQ_GEN : SQ_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_GEN: begin
                    if (last_word) begin
                        state <= SQ_IDLE;
                        cnt   <= '0;
                        blk   <= blk_nxt;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        idle      = 1'b0;
        adv       = 1'b0;
        mix       = 1'b0;
        wr_en     = 1'b0;
        gen_done  = 1'b0;
        seed_done = 1'b0;
        wr_idx    = cnt[IDX_W-1:0];
        unique case (state)
            SQ_IDLE: idle = 1'b1;
            SQ_MIX: begin
                if (cnt == MIX_LAST) begin
                    mix       = 1'b1;
                    seed_done = ~then_gen;
                end
            end
            SQ_GEN: begin
                adv      = 1'b1;
                wr_en    = 1'b1;
                gen_done = last_word;
            end
            default: idle = 1'b0;
        endcase
    end

    // R7
    busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE && $past(state) != SQ_IDLE) |-> $stable(wide_q));

    // R4
    gen_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_GEN) |=> (state == SQ_GEN || state == SQ_IDLE));

    // R3
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_GEN && !wide_q) |-> (cnt < CW'(HALF_WORDS)));

    // R10
    mix_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_MIX && $past(state) == SQ_IDLE) |-> (blk == '0));
endmodule

// File: rtl/cmd_trng_regs.sv
module cmd_trng_regs
    import cmd_trng_pkg::*;
#(
    parameter int          CNT_W   = 16,
    parameter logic [15:0] VERSION = 16'h46BC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq_o,
    input  logic             idle,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      word,
    input  logic             gen_done,
    input  logic             seed_done,
    output logic             start_gen,
    output logic             start_seed,
    output logic             wide,
    output logic [CNT_W-1:0] nblk
);
    logic             mode_q;
    logic [2:0]       ien_q;
    logic [1:0]       stat_q;
    logic [CNT_W-1:0] nblk_q;
    logic [1:0]       stat_clr;
    logic [31:0]      res_w [NUM_WORDS];
    logic             cmd_hit;
    logic             unused_bits;

    assign unused_bits = ^bus_wdata;
    assign cmd_hit     = bus_wr && (bus_addr == OFS_CMD) && idle;
    assign start_gen   = cmd_hit && (bus_wdata[1:0] == OP_GEN);
    assign start_seed  = cmd_hit && (bus_wdata[1:0] == OP_SEED);
    assign wide        = mode_q;
    assign nblk        = nblk_q;
    assign stat_clr    = (bus_wr && bus_addr == OFS_STAT) ? bus_wdata[1:0] : 2'b00;
    assign irq_o       = ien_q[2] & |(ien_q[1:0] & stat_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            ien_q  <= '0;
            nblk_q <= '0;
            stat_q <= 2'b01;
        end else begin
            if (bus_wr && bus_addr == OFS_MODE) mode_q <= bus_wdata[3];
            if (bus_wr && bus_addr == OFS_IEN)  ien_q  <= {bus_wdata[31], bus_wdata[1:0]};
            if (bus_wr && bus_addr == OFS_NBLK) nblk_q <= bus_wdata[CNT_W-1:0];
            stat_q <= (stat_q & ~stat_clr) | {seed_done, gen_done};
        end
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_res
        logic [31:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                r_q <= word;
        end
        assign res_w[g] = r_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE: bus_rdata = {28'd0, mode_q, 3'd0};
            OFS_IEN:  bus_rdata = {ien_q[2], 29'd0, ien_q[1:0]};
            OFS_STAT: bus_rdata = {30'd0, stat_q};
            OFS_NBLK: bus_rdata = 32'(nblk_q);
            OFS_VER:  bus_rdata = 32'(VERSION);
            default: begin
                if (bus_addr[7:5] == 3'b001 && bus_addr[1:0] == 2'b00)
                    bus_rdata = res_w[bus_addr[4:2]];
            end
        endcase
    end

    // R3
    ready_from_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[0]) |-> $past(gen_done));

    // R6
    seeddone_from_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[1]) |-> $past(seed_done));

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STAT && bus_wdata[0] && !gen_done) |=> !stat_q[0]);
endmodule

// File: rtl/cmd_trng.sv
module cmd_trng
    import cmd_trng_pkg::*;
#(
    parameter int          MIX_CYC   = 4,
    parameter int          CNT_W     = 16,
    parameter logic [31:0] SEED_INIT = 32'h2545F491,
    parameter logic [31:0] MIX_KEY   = 32'h9E3779B9,
    parameter logic [15:0] VERSION   = 16'h46BC
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o
);
    logic             idle, adv, mix, wr_en, gen_done, seed_done;
    logic             start_gen, start_seed, wide;
    logic [IDX_W-1:0] wr_idx;
    logic [CNT_W-1:0] nblk;
    logic [31:0]      word;

    cmd_trng_src #(.SEED_INIT(SEED_INIT), .MIX_KEY(MIX_KEY)) u_src (
        .clk(clk), .rst_n(rst_n), .adv(adv), .mix(mix), .nxt_word(word)
    );

    cmd_trng_fsm #(.MIX_CYC(MIX_CYC), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_gen(start_gen), .start_seed(start_seed),
        .wide_in(wide), .nblk(nblk), .idle(idle), .adv(adv), .mix(mix),
        .wr_en(wr_en), .wr_idx(wr_idx), .gen_done(gen_done), .seed_done(seed_done)
    );

    cmd_trng_regs #(.CNT_W(CNT_W), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .idle(idle), .wr_en(wr_en), .wr_idx(wr_idx), .word(word),
        .gen_done(gen_done), .seed_done(seed_done), .start_gen(start_gen),
        .start_seed(start_seed), .wide(wide), .nblk(nblk)
    );
endmodule

// File: tb/cmd_trng_tb.sv
module cmd_trng_tb;
    localparam int CLK_P = 10;
    localparam int MIXN  = 4;
    localparam bit [31:0] KEY = 32'h9E3779B9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // reference model state
    bit [31:0] m_x;
    bit [31:0] m_res [8];
    bit [1:0]  m_st;
    bit        m_mode;
    bit [31:0] m_ie;
    bit [15:0] m_n;
    int        m_blk;
    int        q[$];
    bit [1:0]  setm, clrm;
    int        op, nw;

    cmd_trng u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic bit [31:0] rng(input bit [31:0] v);
        bit [31:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    function automatic bit [31:0] m_read(input bit [7:0] a);
        if (a == 8'h08) return {28'd0, m_mode, 3'd0};
        if (a == 8'h10) return m_ie;
        if (a == 8'h14) return {30'd0, m_st};
        if (a == 8'h60) return {16'd0, m_n};
        if (a == 8'hF0) return 32'h0000_46BC;
        if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 2'b00) return m_res[(a - 8'h20) >> 2];
        return 32'd0;
    endfunction

    task automatic push_mix(input int last_op);
        for (int i = 0; i < MIXN - 1; i++) q.push_back(-1);
        q.push_back(last_op);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_x = 32'h2545F491;
            foreach (m_res[i]) m_res[i] = 32'd0;
            m_st = 2'b01; m_mode = 0; m_ie = 0; m_n = 0; m_blk = 0;
            q.delete();
        end else begin
            setm = 2'b00; clrm = 2'b00;
            if (q.size() != 0) begin
                op = q.pop_front();
                if (op == -2 || op == -3) begin
                    m_x = rng(m_x ^ KEY);
                    if (op == -3) setm[1] = 1'b1;
                end else if (op >= 0) begin
                    m_x = rng(m_x);
                    m_res[op % 100] = m_x;
                    if (op >= 100) begin
                        setm[0] = 1'b1;
                        m_blk += (op == 107) ? 2 : 1;
                    end
                end
            end else if (bus_wr && bus_addr == 8'h00) begin
                if (bus_wdata[1:0] == 2'd1) begin
                    nw = m_mode ? 8 : 4;
                    if (m_n != 0 && m_blk >= m_n) begin
                        m_blk = 0;
                        push_mix(-2);
                    end
                    for (int i = 0; i < nw; i++) q.push_back(i == nw - 1 ? 100 + i : i);
                end else if (bus_wdata[1:0] == 2'd2) begin
                    m_blk = 0;
                    push_mix(-3);
                end
            end
            if (bus_wr) begin
                if (bus_addr == 8'h08) m_mode = bus_wdata[3];
                if (bus_addr == 8'h10) m_ie = bus_wdata & 32'h8000_0003;
                if (bus_addr == 8'h60) m_n = bus_wdata[15:0];
                if (bus_addr == 8'h14) clrm = bus_wdata[1:0];
            end
            m_st = (m_st & ~clrm) | setm;
        end
    end

    task automatic chk(input bit [31:0] act, input bit [31:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // R9: irq compared on every clock
    always @(negedge clk) begin
        #2;
        if (rst_n && !done)
            chk({31'd0, irq_o},
                {31'd0, m_ie[31] & |(m_ie[1:0] & m_st)}, "R9 irq");
    end

    task automatic rd(input bit [7:0] a, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(bus_rdata, m_read(a), tag);
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic poll(input int n, input string tag);
        for (int i = 0; i < n; i++) rd(8'h14, tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 8; i++) rd(8'h20 + 8'(4 * i), tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h14, "R1 status");
        rd(8'h08, "R1 mode");
        rd(8'h10, "R1 ien");
        rd(8'h60, "R1 limit");
        read_all("R1 results");
        chk({31'd0, irq_o}, 32'd0, "R1 irq");
        // R2 version and holes
        rd(8'hF0, "R2 version");
        rd(8'h04, "R2 unmapped");
        rd(8'h70, "R2 unmapped");
        rd(8'h00, "R2 cmd reads zero");
        // R8 write-0 keeps, write-1 clears; R9 enable path
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, "R11 ien readback");
        wr(8'h14, 32'h0);
        rd(8'h14, "R8 write0 keeps");
        wr(8'h14, 32'h1);
        rd(8'h14, "R8 w1c");
        wr(8'h60, 32'hABCD_0000);
        rd(8'h60, "R11 limit readback");
        wr(8'h60, 32'h0);
        // R3 four-word job, R5 values
        wr(8'h00, 32'h1);
        poll(8, "R3 ready timing");
        read_all("R3 R5 half results");
        wr(8'h14, 32'h1);
        // R4 eight-word job with mid-job commands (R7)
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, "R11 mode readback");
        wr(8'h00, 32'h1);
        wr(8'h00, 32'h2);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h1);
        poll(10, "R4 R7 ready timing");
        read_all("R4 R5 full results");
        wr(8'h14, 32'h3);
        // R7 codes 0 and 3 idle
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h3);
        poll(6, "R7 no-op codes");
        read_all("R7 results unchanged");
        // R6 seed
        wr(8'h00, 32'h2);
        poll(7, "R6 seed-done timing");
        read_all("R6 results unchanged");
        wr(8'h10, 32'h8000_0002);
        rd(8'h14, "R9 seed irq pending");
        wr(8'h14, 32'h2);
        rd(8'h14, "R8 seed flag cleared");
        wr(8'h00, 32'h1);
        poll(7, "R6 post-seed gen");
        read_all("R6 R5 post-seed words");
        // R10 auto reseed, limit 2 with four-word jobs
        wr(8'h10, 32'h8000_0001);
        wr(8'h60, 32'h2);
        for (int k = 0; k < 3; k++) begin
            wr(8'h14, 32'h1);
            wr(8'h00, 32'h1);
            poll(11, "R10 reseed timing half");
            read_all("R10 words after reseed");
        end
        // R10 limit 1 with eight-word jobs
        wr(8'h08, 32'h8);
        wr(8'h60, 32'h1);
        for (int k = 0; k < 2; k++) begin
            wr(8'h14, 32'h1);
            wr(8'h00, 32'h1);
            poll(14, "R10 reseed timing full");
            read_all("R10 R4 words");
        end
        // R10 disabled
        wr(8'h60, 32'h0);
        wr(8'h14, 32'h1);
        wr(8'h00, 32'h1);
        poll(10, "R10 disabled timing");
        read_all("R10 disabled words");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule